// File: doc/BRIEF.md
# Read Request Combining Queue

This block is a short request queue for a switch port or link buffer. Read requests arrive with a requester identifier and a byte address. While they wait, a newly arriving read that targets the same 64-byte line as a read already waiting behind the head is not stored. The block answers it at once on a response channel. That answer carries no data. It names the requester whose queued read will fetch the line, so the newcomer can get its copy from that requester's cache. Writes and non-coherent traffic pass through in order and are never merged.

The block keeps no record of a merge once it has answered it. Only the surviving read continues on the request output. The head entry is never a merge target, because it may be leaving the queue in the same cycle. When the response channel is stalled, a read that could have merged is stored as an ordinary entry.

Top module: `req_combine_queue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the queue is empty: out_valid and rsp_valid are 0 and in_ready is 1.
- R2: Stored requests leave on the request output in arrival order. Each one carries its id, address and in_is_read flag unchanged, and the head stays stable while out_ready is low.
- R3: Two addresses match when bits ADDR_W-1 down to 6 are equal. The low 6 bits are ignored. Addresses that differ in any higher bit never match.
- R4: A read merges when in_is_read=1, it matches a stored read that is not at the head, and rsp_ready=1. In that cycle in_ready=1 and rsp_valid=1, rsp_id equals in_id, and the request is not stored, so it never appears on the request output.
- R5: When several non-head entries match, rsp_holder names the id of the oldest of them.
- R6: The head entry is never a merge target. A read that matches only the head is stored normally.
- R7: A request with in_is_read=0 never produces rsp_valid. A stored entry with in_is_read=0 is never a merge target.
- R8: When a merge candidate exists but rsp_ready=0, rsp_valid still shows the candidate. The request is then stored as an ordinary entry if there is room.
- R9: With DEPTH entries stored, in_ready is 0 unless a merge completes in that cycle, and a merge is still accepted while the queue is full. The number of stored entries never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming request present |
| in_ready | output | 1 | Incoming request accepted (stored or merged) |
| in_id | input | ID_W | Requester identifier |
| in_addr | input | ADDR_W | Byte address |
| in_is_read | input | 1 | 1 for a coherent read; 0 for a write or non-coherent request |
| out_valid | output | 1 | Head request available |
| out_ready | input | 1 | Downstream takes the head request |
| out_id | output | ID_W | Head requester identifier |
| out_addr | output | ADDR_W | Head address |
| out_is_read | output | 1 | Head read flag |
| rsp_valid | output | 1 | Redirect response for the incoming request |
| rsp_ready | input | 1 | Response channel can take a response |
| rsp_id | output | ID_W | Requester being answered |
| rsp_holder | output | ID_W | Requester whose read survives |

## Verification
The bench builds the block with DEPTH=4, ID_W=4 and ADDR_W=12. That leaves six line-address bits above the ignored offset. With only four slots, the bench reaches the full queue, the wrap of the circular pointers, and a match against every age position within a few cycles. Directed sequences cover the head-only match, writes on a shared line, a stalled response channel and several matches at once. A long pseudo-random sweep then draws addresses from four lines with random offsets and random ready patterns, and checks every output against a bench model in every cycle.

// File: rtl/req_combine_queue.sv
module req_combine_queue #(
  parameter int DEPTH    = 8,
  parameter int ID_W     = 6,
  parameter int ADDR_W   = 40,
  parameter int LINE_LSB = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_is_read,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_is_read,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ID_W-1:0]   rsp_id,
  output logic [ID_W-1:0]   rsp_holder
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam int LN_W  = ADDR_W - LINE_LSB;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DEPTH-1:0]  rd_q;
  logic [PTR_W-1:0]  head;
  logic [CNT_W-1:0]  cnt;

  logic [DEPTH-1:0]  hit;
  logic              found;
  logic [PTR_W-1:0]  sel_slot;
  logic [LN_W-1:0]   in_line;
  logic              merge, deq, enq, full;
  logic [PTR_W-1:0]  wr_ptr;

  assign in_line = in_addr[ADDR_W-1:LINE_LSB];
  assign full    = (cnt == FULL);
  assign wr_ptr  = head + cnt[PTR_W-1:0];

  assign hit[0] = 1'b0;
  for (genvar g = 1; g < DEPTH; g++) begin : g_cmp
    localparam logic [PTR_W-1:0] OFS = PTR_W'(g);
    localparam logic [CNT_W-1:0] AGE = CNT_W'(g);
    logic [PTR_W-1:0] slot;
    assign slot   = head + OFS;
    assign hit[g] = (cnt > AGE) && rd_q[slot] &&
                    (addr_q[slot][ADDR_W-1:LINE_LSB] == in_line);
  end

  always_comb begin
    found    = 1'b0;
    sel_slot = head;
    for (int k = DEPTH - 1; k >= 1; k--) begin
      if (hit[k]) begin
        found    = 1'b1;
        sel_slot = head + PTR_W'(k);
      end
    end
  end

  assign rsp_valid  = in_valid && in_is_read && found;
  assign rsp_id     = in_id;
  assign rsp_holder = id_q[sel_slot];
  assign merge      = rsp_valid && rsp_ready;
  assign in_ready   = merge || !full;

  assign out_valid   = (cnt != '0);
  assign out_id      = id_q[head];
  assign out_addr    = addr_q[head];
  assign out_is_read = rd_q[head];

  assign deq = out_valid && out_ready;
  assign enq = in_valid && !merge && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      cnt  <= '0;
      rd_q <= '0;
    end else begin
      if (enq) begin
        id_q[wr_ptr]   <= in_id;
        addr_q[wr_ptr] <= in_addr;
        rd_q[wr_ptr]   <= in_is_read;
      end
      if (deq) head <= head + PTR_W'(1);
      case ({enq, deq})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL); // R9
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !(rsp_valid && rsp_ready)) |-> !in_ready); // R9
  AST_MERGE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !(out_valid && out_ready)) |=> $stable(cnt)); // R4
  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id) && $stable(out_addr))); // R2
  AST_RSP_ONLY_READS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (in_valid && in_is_read)); // R7
endmodule

// File: tb/req_combine_queue_bench.sv
`timescale 1ns/1ps
module req_combine_queue_bench;
  localparam int D = 4, IW = 4, AW = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_is_read, out_valid, out_ready, out_is_read;
  logic rsp_valid, rsp_ready;
  logic [IW-1:0] in_id, out_id, rsp_id, rsp_holder;
  logic [AW-1:0] in_addr, out_addr;

  req_combine_queue #(.DEPTH(D), .ID_W(IW), .ADDR_W(AW), .LINE_LSB(6)) u_req_combine_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id),
    .in_addr(in_addr), .in_is_read(in_is_read), .out_valid(out_valid), .out_ready(out_ready),
    .out_id(out_id), .out_addr(out_addr), .out_is_read(out_is_read), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_holder(rsp_holder));

  logic [IW-1:0] m_id [D];
  logic [AW-1:0] m_addr [D];
  logic          m_rd [D];
  int m_n = 0;
  int n_chk = 0, n_bad = 0;
  string tag = "R1 reset";

  task automatic cmp(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] ad(input int line, input int low);
    return AW'((line << 6) | (low & 63));
  endfunction

  task automatic step(input logic v, input int id, input logic [AW-1:0] a, input logic rd,
                      input logic ordy, input logic rrdy);
    int sel;
    logic fnd, mrg, eq, dq;
    in_valid = v; in_id = IW'(id); in_addr = a; in_is_read = rd;
    out_ready = ordy; rsp_ready = rrdy;
    #1;
    fnd = 1'b0; sel = 0;
    for (int k = 1; k < m_n; k++)
      if (!fnd && m_rd[k] && (m_addr[k][AW-1:6] == a[AW-1:6])) begin fnd = 1'b1; sel = k; end
    fnd = fnd && v && rd;
    mrg = fnd && rrdy;
    cmp("out_valid", 32'(out_valid), 32'(m_n > 0));
    if (m_n > 0) begin
      cmp("out_id", 32'(out_id), 32'(m_id[0]));
      cmp("out_addr", 32'(out_addr), 32'(m_addr[0]));
      cmp("out_is_read", 32'(out_is_read), 32'(m_rd[0]));
    end
    cmp("rsp_valid", 32'(rsp_valid), 32'(fnd));
    if (fnd) begin
      cmp("rsp_holder", 32'(rsp_holder), 32'(m_id[sel]));
      cmp("rsp_id", 32'(rsp_id), 32'(id));
    end
    cmp("in_ready", 32'(in_ready), 32'(mrg || (m_n < D)));
    dq = (m_n > 0) && ordy;
    eq = v && !mrg && (m_n < D);
    @(posedge clk);
    if (dq) begin
      for (int k = 0; k < D - 1; k++) begin
        m_id[k] = m_id[k+1]; m_addr[k] = m_addr[k+1]; m_rd[k] = m_rd[k+1];
      end
      m_n--;
    end
    if (eq) begin
      m_id[m_n] = IW'(id); m_addr[m_n] = a; m_rd[m_n] = rd; m_n++;
    end
    @(negedge clk);
  endtask

  task automatic drain();
    while (m_n > 0) step(1'b0, 0, '0, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; in_valid = 0; in_id = '0; in_addr = '0; in_is_read = 0;
    out_ready = 0; rsp_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1 reset";
    cmp("out_valid", 32'(out_valid), 0);
    cmp("rsp_valid", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    step(1'b0, 0, '0, 1'b0, 1'b0, 1'b1);

    tag = "R2 R6 R7 R9 fill";
    step(1, 1, ad(5, 0), 1, 0, 1);
    step(1, 2, ad(5, 8), 0, 0, 1);
    step(1, 3, ad(5, 9), 1, 0, 1);
    step(1, 4, ad(9, 1), 1, 0, 1);
    step(1, 5, ad(9, 2), 1, 0, 1);
    step(1, 6, ad(2, 0), 1, 0, 1);
    step(1, 7, ad(9, 3), 0, 0, 1);
    drain();

    tag = "R3 line match";
    step(1, 1, ad(3, 0), 1, 0, 1);
    step(1, 2, ad(3, 1), 1, 0, 1);
    step(1, 3, ad(3, 63), 1, 0, 1);
    step(1, 4, ad(2, 5), 1, 0, 1);
    step(1, 5, ad(35, 5), 1, 0, 1);
    drain();

    tag = "R5 R8 oldest and stalled response";
    step(1, 1, ad(7, 0), 1, 0, 0);
    step(1, 2, ad(7, 4), 1, 0, 0);
    step(1, 3, ad(7, 8), 1, 0, 0);
    step(1, 4, ad(7, 12), 1, 0, 1);
    step(1, 5, ad(7, 16), 1, 1, 1);
    drain();

    tag = "R4 sweep";
    lf = 16'hACE1;
    for (int c = 0; c < 6000; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[5], int'(lf[11:8]), ad(int'(lf[3:2]), int'(lf[15:10])), lf[7] | lf[9],
           (c % 300 < 150) ? lf[4] : (lf[4] & lf[6]), lf[1] | lf[12]);
    end
    drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule